// File: doc/BRIEF.md
# Condition-Code Flag Evaluator

This block turns the operands and result of the last arithmetic, logic, multiply or bit-test operation into the negative, zero, overflow and carry flags. It merges them into the processor status word. The execution stage presents the source operand, destination operand and result, plus the upper word of a multiply product when there is one. It also presents the operand size, the operation class, the set of flags the instruction is allowed to update, the current extended-arithmetic flag and the current status word. One clock edge later the block returns the new status word with a one-cycle valid pulse.

Carry is derived only from the sign bits of the source, destination and result at the operand size, never from a full adder. This lets the unit sit beside the ALU without needing the ALU's carry chain. Extended (multi-word) arithmetic keeps a zero flag sticky: a zero result cannot set it, only keep or clear it.

Status word bit positions: C = bit 0, V = bit 1, Z = bit 2, N = bit 3, X = bit 4, R = bit 8. Operation class codes (`op_class`): 0 add/ALU, 1 sub/cmp, 2 move/logic/shift, 3 mcp, 4 signed multiply, 5 unsigned multiply, 6 bit test, 7 flags-live. Size codes (`size_code`): 0 byte (sign bit 7), 1 halfword (sign bit 15), 2 and 3 word (sign bit 31).

Top module: `ccflag_eval`

## Requirements
- R1: Add class (code 0) at the selected size: if the result sign is 1, N=1, V=1 when both operand signs are 0, and C=1 when both are 1. Otherwise Z=1 when the result masked to the size is zero, V=1 when both operand signs are 1, and C=1 when either sign is 1. Flags not named are computed as 0.
- R2: Sub/cmp class (code 1) applies the R1 rules to the bit-inverted source and then inverts the computed C.
- R3: Mcp class (code 3) applies the R1 rules at the full 32-bit width whatever the size code. The carry-rule result goes to R (bit 8), and C is computed as 0.
- R4: Move/logic/shift class (code 2) at half or word size computes N from the result sign at that size, or Z if the result at that size is zero, with V and C computed as 0. At byte size it uses the R1 rules.
- R5: Unsigned multiply (code 5): Z=1 when the 64-bit value {mul_hi, res_val} is zero, N = bit 63 of that value, and V=1 when mul_hi is nonzero.
- R6: Signed multiply (code 4): Z and N as in R5, and V=1 when mul_hi differs from 32 copies of res_val bit 31.
- R7: The effective update set is upd_mask with the X bit (bit 4) added. Status bits in the set take the computed value, with X computed as 0. Bits outside it keep their status_in value.
- R8: When x_active is 1 and the computed Z is 1, Z is dropped from the update set, so a zero result never sets Z during extended arithmetic.
- R9: Bit test (code 6) takes the bit index from src_val[4:0] and the tested value from dst_val. N = the selected bit, and Z=1 when the selected bit and all lower bits are zero. X is cleared. V and C are cleared when cpu_version is below 32. All other bits keep status_in, and upd_mask and x_active have no effect.
- R10: Flags-live class (code 7) returns status_in unchanged.
- R11: status_out and out_valid are registered. A request with in_valid=1 appears on status_out the clock edge after it is presented, with out_valid=1 for that one cycle. Without in_valid, out_valid is 0 and status_out holds. Synchronous reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_class | input | 3 | Operation class code |
| size_code | input | 2 | Operand size code |
| src_val | input | 32 | Source operand (bit index for bit test) |
| dst_val | input | 32 | Destination operand |
| res_val | input | 32 | Operation result (low product word for multiply) |
| mul_hi | input | 32 | Upper product word |
| upd_mask | input | 32 | Flags the instruction may update |
| x_active | input | 1 | Current extended-arithmetic flag |
| cpu_version | input | 8 | Core version number |
| status_in | input | 32 | Current status word |
| status_out | output | 32 | New status word |
| out_valid | output | 1 | New status word valid |

## Verification
Every result is due exactly one clock edge after its request, because the only storage on the path is the output register. The bench drives each request on a falling edge, waits for the next rising edge and then samples a nanosecond later. There it compares status_out and out_valid with a value its own model computes from the same inputs. Idle cycles are checked the same way one edge after in_valid drops, to confirm that out_valid falls and status_out holds.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

  // Status word flag positions
  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int BIT_X = 4;
  localparam int BIT_R = 8;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'd0,
    OPC_SUB  = 3'd1,
    OPC_MOVE = 3'd2,
    OPC_MCP  = 3'd3,
    OPC_MULS = 3'd4,
    OPC_MULU = 3'd5,
    OPC_BTST = 3'd6,
    OPC_LIVE = 3'd7
  } opc_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

endpackage

// File: rtl/ccf_arith_eval.sv
module ccf_arith_eval
  import ccflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [1:0]        size_i,
  input  logic              inv_src_i,
  output nzvc_t             flags_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] MASK_B = DATA_W'(8'hFF);
  localparam logic [DATA_W-1:0] MASK_H = DATA_W'(16'hFFFF);
  localparam logic [DATA_W-1:0] MASK_W = '1;

  logic [DATA_W-1:0] s_eff;
  logic [DATA_W-1:0] size_mask;
  logic [IDX_W-1:0]  sgn_idx;
  logic              s_sgn, d_sgn, r_sgn, r_zero;

  always_comb begin
    s_eff = inv_src_i ? ~src_i : src_i;
    case (size_i)
      SZ_BYTE: begin size_mask = MASK_B; sgn_idx = IDX_W'(7);  end
      SZ_HALF: begin size_mask = MASK_H; sgn_idx = IDX_W'(15); end
      default: begin size_mask = MASK_W; sgn_idx = IDX_W'(DATA_W-1); end
    endcase
    s_sgn  = s_eff[sgn_idx];
    d_sgn  = dst_i[sgn_idx];
    r_sgn  = res_i[sgn_idx];
    r_zero = ((res_i & size_mask) == '0);
  end

  always_comb begin
    flags_o = '0;
    if (r_sgn) begin
      flags_o.n = 1'b1;
      flags_o.v = ~s_sgn & ~d_sgn;
      flags_o.c = s_sgn & d_sgn;
    end else begin
      flags_o.z = r_zero;
      flags_o.v = s_sgn & d_sgn;
      flags_o.c = s_sgn | d_sgn;
    end
    if (inv_src_i) flags_o.c = ~flags_o.c;
  end

endmodule

// File: rtl/ccf_logic_eval.sv
module ccf_logic_eval
  import ccflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic [1:0]        size_i,
  output nzvc_t             flags_o
);
  localparam int HALF_W = 16;

  logic sgn, zero;

  always_comb begin
    if (size_i == SZ_HALF) begin
      sgn  = res_i[HALF_W-1];
      zero = (res_i[HALF_W-1:0] == '0);
    end else begin
      sgn  = res_i[DATA_W-1];
      zero = (res_i == '0);
    end
    flags_o   = '0;
    flags_o.n = sgn;
    flags_o.z = ~sgn & zero;
  end

endmodule

// File: rtl/ccf_mul_eval.sv
module ccf_mul_eval
  import ccflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic              signed_i,
  output nzvc_t             flags_o
);
  logic hi_zero, hi_ext;

  always_comb begin
    hi_zero   = (hi_i == '0);
    hi_ext    = (hi_i == {DATA_W{lo_i[DATA_W-1]}});
    flags_o   = '0;
    flags_o.z = hi_zero & (lo_i == '0);
    flags_o.n = hi_i[DATA_W-1];
    flags_o.v = signed_i ? ~hi_ext : ~hi_zero;
  end

endmodule

// File: rtl/ccf_btst_eval.sv
module ccf_btst_eval #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         val_i,
  input  logic [$clog2(DATA_W)-1:0] idx_i,
  output logic                      bit_o,
  output logic                      low_zero_o
);
  logic [DATA_W-1:0] low_mask;

  always_comb begin
    low_mask   = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(idx_i));
    bit_o      = val_i[idx_i];
    low_zero_o = ((val_i & low_mask) == '0);
  end

endmodule

// File: rtl/ccflag_eval.sv
module ccflag_eval
  import ccflag_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int STAT_W      = 32,
  parameter int VER_W       = 8,
  parameter int VER_NEW_MIN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_class,
  input  logic [1:0]        size_code,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] res_val,
  input  logic [DATA_W-1:0] mul_hi,
  input  logic [STAT_W-1:0] upd_mask,
  input  logic              x_active,
  input  logic [VER_W-1:0]  cpu_version,
  input  logic [STAT_W-1:0] status_in,
  output logic [STAT_W-1:0] status_out,
  output logic              out_valid
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [STAT_W-1:0] X_ONLY = STAT_W'(1) << BIT_X;

  opc_e op;
  assign op = opc_e'(op_class);

  nzvc_t fl_arith, fl_mcp, fl_logic, fl_mul, fl_sel;
  logic  bt_bit, bt_lowz;

  ccf_arith_eval #(.DATA_W(DATA_W)) u_arith (
    .src_i(src_val), .dst_i(dst_val), .res_i(res_val),
    .size_i(size_code), .inv_src_i(op == OPC_SUB), .flags_o(fl_arith)
  );

  ccf_arith_eval #(.DATA_W(DATA_W)) u_mcp (
    .src_i(src_val), .dst_i(dst_val), .res_i(res_val),
    .size_i(SZ_WORD), .inv_src_i(1'b0), .flags_o(fl_mcp)
  );

  ccf_logic_eval #(.DATA_W(DATA_W)) u_logic (
    .res_i(res_val), .size_i(size_code), .flags_o(fl_logic)
  );

  ccf_mul_eval #(.DATA_W(DATA_W)) u_mul (
    .lo_i(res_val), .hi_i(mul_hi), .signed_i(op == OPC_MULS), .flags_o(fl_mul)
  );

  ccf_btst_eval #(.DATA_W(DATA_W)) u_btst (
    .val_i(dst_val), .idx_i(src_val[IDX_W-1:0]),
    .bit_o(bt_bit), .low_zero_o(bt_lowz)
  );

  // Flag source selection
  always_comb begin
    case (op)
      OPC_MCP:             fl_sel = fl_mcp;
      OPC_MULS, OPC_MULU:  fl_sel = fl_mul;
      OPC_MOVE:            fl_sel = (size_code == SZ_BYTE) ? fl_arith : fl_logic;
      default:             fl_sel = fl_arith;
    endcase
  end

  logic [STAT_W-1:0] flag_vec, wb_mask, merged, bt_stat, next_stat;

  always_comb begin
    flag_vec        = '0;
    flag_vec[BIT_N] = fl_sel.n;
    flag_vec[BIT_Z] = fl_sel.z;
    flag_vec[BIT_V] = fl_sel.v;
    if (op == OPC_MCP) flag_vec[BIT_R] = fl_sel.c;
    else               flag_vec[BIT_C] = fl_sel.c;

    wb_mask = upd_mask | X_ONLY;
    if (x_active && flag_vec[BIT_Z]) wb_mask[BIT_Z] = 1'b0;
    merged = (status_in & ~wb_mask) | (flag_vec & wb_mask);

    bt_stat        = status_in;
    bt_stat[BIT_X] = 1'b0;
    bt_stat[BIT_N] = bt_bit;
    bt_stat[BIT_Z] = bt_lowz;
    if (cpu_version < VER_W'(VER_NEW_MIN)) begin
      bt_stat[BIT_V] = 1'b0;
      bt_stat[BIT_C] = 1'b0;
    end

    case (op)
      OPC_LIVE: next_stat = status_in;
      OPC_BTST: next_stat = bt_stat;
      default:  next_stat = merged;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_out <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) status_out <= next_stat;
    end
  end

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(status_out)));
  // R10
  live_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 3'd7) |=> (status_out == $past(status_in)));
  // R9
  btst_xclr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 3'd6) |=> !status_out[BIT_X]);
  // R7
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class < 3'd6) |=>
      (((status_out ^ $past(status_in)) & ~($past(upd_mask) | X_ONLY)) == '0));
  // R8
  sticky_z_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class < 3'd6 && x_active && !status_in[BIT_Z]) |=> !status_out[BIT_Z]);
  // R5
  mulu_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 3'd5 && upd_mask[BIT_V] && mul_hi != '0) |=> status_out[BIT_V]);

endmodule

// File: tb/ccflag_eval_tb.sv
`timescale 1ns/1ps
module ccflag_eval_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op_class;
  logic [1:0]  size_code;
  logic [31:0] src_val, dst_val, res_val, mul_hi, upd_mask, status_in;
  logic        x_active;
  logic [7:0]  cpu_version;
  logic [31:0] status_out;
  logic        out_valid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ccflag_eval u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
    .size_code(size_code), .src_val(src_val), .dst_val(dst_val),
    .res_val(res_val), .mul_hi(mul_hi), .upd_mask(upd_mask),
    .x_active(x_active), .cpu_version(cpu_version), .status_in(status_in),
    .status_out(status_out), .out_valid(out_valid)
  );

  function automatic logic [31:0] model(
    input logic [2:0] op, input logic [1:0] sz, input logic [31:0] s,
    input logic [31:0] d, input logic [31:0] r, input logic [31:0] h,
    input logic [31:0] m, input logic x, input logic [7:0] ver,
    input logic [31:0] st);
    logic [31:0] e, fv, mk, se;
    logic [63:0] p;
    int w, k;
    logic ss, ds, rs, rz, fn, fz, fvv, fc;
    fn = 0; fz = 0; fvv = 0; fc = 0;
    if (op == 3'd7) return st;
    if (op == 3'd6) begin
      k = int'(s[4:0]);
      e = st;
      e[4] = 1'b0;
      e[3] = d[k];
      e[2] = ((d << (31 - k)) == 32'd0);
      if (ver < 8'd32) begin e[1] = 1'b0; e[0] = 1'b0; end
      return e;
    end
    if (op == 3'd4 || op == 3'd5) begin
      p = {h, r};
      fz = (p == 64'd0);
      fn = p[63];
      fvv = (op == 3'd5) ? (h != 0) : (h != (r[31] ? 32'hFFFF_FFFF : 32'd0));
    end else begin
      w = (op == 3'd3) ? 32 : (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      rs = r[w-1];
      rz = ((r << (32 - w)) == 32'd0);
      if (op == 3'd2 && sz != 2'd0) begin
        fn = rs; fz = !rs && rz;
      end else begin
        se = (op == 3'd1) ? ~s : s;
        ss = se[w-1]; ds = d[w-1];
        if (rs) begin fn = 1; fvv = !ss && !ds; fc = ss && ds; end
        else    begin fz = rz; fvv = ss && ds; fc = ss || ds; end
        if (op == 3'd1) fc = !fc;
      end
    end
    fv = 32'd0;
    fv[3] = fn; fv[2] = fz; fv[1] = fvv;
    if (op == 3'd3) fv[8] = fc; else fv[0] = fc;
    mk = m | 32'h10;
    if (x && fz) mk[2] = 1'b0;
    return (st & ~mk) | (fv & mk);
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R3";
      3'd4: return "R6";
      3'd5: return "R5";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic txn(input string tag, input logic [2:0] op, input logic [1:0] sz,
                     input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
                     input logic [31:0] h, input logic [31:0] m, input logic x,
                     input logic [7:0] ver, input logic [31:0] st);
    logic [31:0] exp_v;
    @(negedge clk);
    in_valid = 1; op_class = op; size_code = sz; src_val = s; dst_val = d;
    res_val = r; mul_hi = h; upd_mask = m; x_active = x; cpu_version = ver;
    status_in = st;
    exp_v = model(op, sz, s, d, r, h, m, x, ver, st);
    @(posedge clk); #1;
    checks++;
    if (status_out !== exp_v || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s op=%0d sz=%0d: status_out=%h valid=%b expected %h valid=1",
               tag, op, sz, status_out, out_valid, exp_v);
    end
  endtask

  task automatic idle_check();
    logic [31:0] held;
    held = status_out;
    @(negedge clk);
    in_valid = 0;
    status_in = $urandom;
    @(posedge clk); #1;
    checks++;
    if (out_valid !== 1'b0 || status_out !== held) begin
      errors++;
      $display("FAIL R11 idle: status_out=%h valid=%b expected %h valid=0",
               status_out, out_valid, held);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] all_flags;
    all_flags = 32'h10F;
    void'($urandom(32'd4711));
    rst = 1; in_valid = 0; op_class = 0; size_code = 0; src_val = 0;
    dst_val = 0; res_val = 0; mul_hi = 0; upd_mask = 0; x_active = 0;
    cpu_version = 0; status_in = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (status_out !== 32'd0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: status_out=%h valid=%b expected 0 valid=0", status_out, out_valid);
    end
    @(negedge clk); rst = 0;

    // R1 byte add overflow into sign, and word add with both signs set
    txn("R1", 3'd0, 2'd0, 32'h01, 32'h7F, 32'h80, 0, all_flags, 0, 8'd10, 32'h0);
    txn("R1", 3'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, all_flags, 0, 8'd10, 32'h0);
    txn("R1", 3'd0, 2'd1, 32'hFFFF_0000, 32'h0, 32'h0001_0000, 0, all_flags, 0, 8'd10, 32'h0);
    // R2 equal compare: zero, no borrow
    txn("R2", 3'd1, 2'd2, 32'd5, 32'd5, 32'd0, 0, all_flags, 0, 8'd10, 32'hF);
    txn("R2", 3'd1, 2'd0, 32'd6, 32'd5, 32'hFF, 0, all_flags, 0, 8'd10, 32'h0);
    // R3 mcp uses word width and R bit
    txn("R3", 3'd3, 2'd0, 32'h8000_0000, 32'h1, 32'h0000_0080, 0, all_flags, 0, 8'd10, 32'h1);
    // R4 move half negative, word zero, byte fallback
    txn("R4", 3'd2, 2'd1, 32'h0, 32'h0, 32'h0000_8000, 0, all_flags, 0, 8'd10, 32'h3);
    txn("R4", 3'd2, 2'd2, 32'h0, 32'h0, 32'h0, 0, all_flags, 0, 8'd10, 32'h3);
    txn("R4", 3'd2, 2'd0, 32'h80, 32'h80, 32'h00, 0, all_flags, 0, 8'd10, 32'h0);
    // R5 / R6 multiply overflow detection
    txn("R5", 3'd5, 2'd2, 0, 0, 32'h0, 32'h1, all_flags, 0, 8'd10, 32'h0);
    txn("R6", 3'd4, 2'd2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, all_flags, 0, 8'd10, 32'h0);
    txn("R6", 3'd4, 2'd2, 0, 0, 32'h7000_0000, 32'hFFFF_FFFF, all_flags, 0, 8'd10, 32'h0);
    // R7 restricted mask keeps other bits
    txn("R7", 3'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'h4, 0, 8'd10, 32'hFFFF_FFFB);
    // R8 sticky zero during extended arithmetic
    txn("R8", 3'd0, 2'd2, 32'h0, 32'h0, 32'h0, 0, all_flags, 1, 8'd10, 32'h0);
    txn("R8", 3'd0, 2'd2, 32'h0, 32'h0, 32'h5, 0, all_flags, 1, 8'd10, 32'h4);
    // R9 bit test at both index ends and both version ranges
    txn("R9", 3'd6, 2'd2, 32'd31, 32'h8000_0000, 0, 0, 32'h0, 1, 8'd10, 32'hFFFF_FFFF);
    txn("R9", 3'd6, 2'd2, 32'h20, 32'h2, 0, 0, 32'hFFFF_FFFF, 0, 8'd40, 32'h13);
    // R10 live class
    txn("R10", 3'd7, 2'd2, 32'h1, 32'h1, 32'h1, 32'h1, 32'hFFFF_FFFF, 1, 8'd10, 32'hA5A5_5A5A);
    idle_check();

    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      logic [31:0] r;
      op = 3'($urandom_range(0, 7));
      r = ($urandom_range(0, 5) == 0) ? 32'd0 : $urandom;
      txn(tag_of(op), op, 2'($urandom_range(0, 3)), $urandom, $urandom, r,
          ($urandom_range(0, 3) == 0) ? {32{r[31]}} : $urandom,
          ($urandom_range(0, 2) == 0) ? 32'hFFFF_FFFF : $urandom,
          1'($urandom_range(0, 1)), 8'($urandom_range(0, 63)), $urandom);
      if (i % 50 == 0) idle_check();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule